// File: doc/BRIEF.md
# High-Speed Oscillator Enable Control Register

This block is a single 32-bit memory-mapped control word for the two high-speed oscillators of a small microcontroller: an internal RC oscillator and an external crystal oscillator. Software writes it over a simple bus with per-byte strobes and reads it back with no wait cycles. The word holds each oscillator's enable and ready flag, a 5-bit frequency trim that drives the internal oscillator directly, and an 8-bit calibration value that is captured from a factory input once after reset.

Hardware events act on the enables alongside software writes. Reset causes and wake-ups turn the internal oscillator on. So does a failure of the external oscillator while it is feeding the system clock. Entry to a low-power mode turns the external oscillator off. Software cannot switch off an oscillator that is currently driving the system clock, either directly or through the PLL.

Top module: `osc_ctrl_reg`

## Requirements
- R1: While reset is held, the word reads 0x0000_0083: internal enable (bit 0) = 1, internal ready (bit 1) = 1, trim (bits 7:3) = 5'b10000, calibration (bits 15:8) = 0, external enable (bit 16) = 0, external ready (bit 17) = 0. The `int_osc_en` output is 1, `ext_osc_en` is 0 and `trim_out` is 5'h10.
- R2: The calibration field captures `cal_in` on the first clock edge after reset is released. After that it keeps its value when `cal_in` changes, and writes to byte 1 do not alter it.
- R3: A write hits only when `wr_en` is 1 and `addr` equals the register offset 0x00. Only bytes whose `wstrb` bit is set are updated. Byte 0 carries the internal enable (bit 0) and the trim (bits 7:3), and the new trim appears on `trim_out`.
- R4: A write to byte 0 with bit 0 = 1 sets the internal enable, and with bit 0 = 0 clears it when the internal oscillator is not locked. The result is visible on the next cycle.
- R5: The internal oscillator is locked when `sysclk_src` = 2'b00 (internal), or when `sysclk_src` = 2'b10 (PLL) and `pll_from_ext` = 0. While it is locked, a write of 0 to bit 0 leaves the internal enable at 1.
- R6: A pulse on `por_evt`, `swrst_evt`, `wake_stop` or `wake_standby` sets the internal enable to 1, even when a write of 0 to bit 0 arrives in the same cycle.
- R7: A pulse on `ext_fail` sets the internal enable only while the external oscillator feeds the system clock (`sysclk_src` = 2'b01, or 2'b10 with `pll_from_ext` = 1). With `sysclk_src` = 2'b11 (another source), the pulse has no effect.
- R8: A write to byte 2 with bit 16 = 1 sets the external enable, and with bit 16 = 0 clears it. The clear is ignored while the external oscillator feeds the system clock, as defined in R7.
- R9: A pulse on `enter_stop` or `enter_standby` clears the external enable, even when a write of 1 to bit 16 arrives in the same cycle.
- R10: The external ready flag (bit 17) is set on any cycle with `ext_stable` = 1. A byte-2 write of 0 to bit 17 clears it, unless `ext_stable` = 1 in that cycle. Writing 1 to bit 17 has no effect.
- R11: The internal ready flag reads as `int_stable` registered by one cycle, and reads 0 whenever the internal enable is 0.
- R12: The read data is combinational. It shows the word in the same cycle when `rd_en` = 1 and `addr` = 0x00, and is 0 otherwise. Bits 2 and 31:18 always read 0. Writes to byte 3, or to any other address, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte write strobes |
| rdata | output | 32 | Read data, same cycle |
| int_stable | input | 1 | Internal oscillator reports stable |
| ext_stable | input | 1 | External oscillator reports stable |
| sysclk_src | input | 2 | System clock source: 00 internal, 01 external, 10 PLL, 11 other |
| pll_from_ext | input | 1 | PLL reference: 0 internal, 1 external |
| por_evt | input | 1 | Power-on pulse |
| swrst_evt | input | 1 | Software reset pulse |
| wake_stop | input | 1 | Wake from stop pulse |
| wake_standby | input | 1 | Wake from standby pulse |
| enter_stop | input | 1 | Stop entry pulse |
| enter_standby | input | 1 | Standby entry pulse |
| ext_fail | input | 1 | External clock failure pulse |
| cal_in | input | 8 | Factory calibration value |
| int_osc_en | output | 1 | Internal oscillator enable |
| ext_osc_en | output | 1 | External oscillator enable |
| trim_out | output | 5 | Internal oscillator trim |

## Verification
Two functions can fall in the same clock cycle: a software write to an enable or to the ready flag, and a hardware event that forces the same bit. The bench provokes this by driving the write and the event pulse, or the stable indication, on the same cycle. Cases covered are a wake or reset-cause pulse against a write of 0 to the internal enable, a low-power entry against a write of 1 to the external enable, and `ext_stable` against a software clear of the external ready flag. The bench then reads the word back on the next cycle. It judges the outcome against the rule that the hardware event wins, and checks the enable pins as well as the read data.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

    typedef enum logic [1:0] {
        SRC_INT   = 2'b00,
        SRC_EXT   = 2'b01,
        SRC_PLL   = 2'b10,
        SRC_OTHER = 2'b11
    } clk_src_e;

    localparam int TRIM_W   = 5;
    localparam int CAL_W    = 8;
    localparam int TRIM_LSB = 3;
    localparam int CAL_LSB  = TRIM_LSB + TRIM_W;
    localparam logic [TRIM_W-1:0] TRIM_RST = 5'b10000;

    typedef struct packed {
        logic [13:0]       rsvd_hi;
        logic              ext_rdy;
        logic              ext_en;
        logic [CAL_W-1:0]  cal;
        logic [TRIM_W-1:0] trim;
        logic              rsvd_lo;
        logic              int_rdy;
        logic              int_en;
    } osc_word_t;

    // True when the chosen oscillator drives the system clock directly or via the PLL
    function automatic logic drives_sysclk(clk_src_e src, logic pll_ext, logic want_ext);
        logic direct;
        direct = want_ext ? (src == SRC_EXT) : (src == SRC_INT);
        return direct || (src == SRC_PLL && pll_ext == want_ext);
    endfunction

endpackage

// File: rtl/osc_int_ctl.sv
module osc_int_ctl (
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic wr_val,
    input  logic locked,
    input  logic force_on,
    input  logic stable_in,
    output logic en_o,
    output logic rdy_o
);
    logic en_q;
    logic stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b1;
            stable_q <= 1'b1;
        end else begin
            stable_q <= stable_in;
            if (force_on)
                en_q <= 1'b1;
            else if (wr_hit)
                en_q <= wr_val | (locked & en_q);
        end
    end

    assign en_o  = en_q;
    assign rdy_o = en_q & stable_q;

    // R6
    int_force_chk: assert property (@(posedge clk) disable iff (rst) force_on |=> en_o);
    // R5
    int_hold_chk: assert property (@(posedge clk) disable iff (rst) (locked && en_o) |=> en_o);

endmodule

// File: rtl/osc_ext_ctl.sv
module osc_ext_ctl (
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic wr_en_val,
    input  logic wr_rdy_val,
    input  logic locked,
    input  logic force_off,
    input  logic stable_in,
    output logic en_o,
    output logic rdy_o
);
    logic en_q;
    logic rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            rdy_q <= 1'b0;
        end else begin
            if (force_off)
                en_q <= 1'b0;
            else if (wr_hit)
                en_q <= wr_en_val | (locked & en_q);

            if (stable_in)
                rdy_q <= 1'b1;
            else if (wr_hit && !wr_rdy_val)
                rdy_q <= 1'b0;
        end
    end

    assign en_o  = en_q;
    assign rdy_o = rdy_q;

    // R9
    ext_off_chk: assert property (@(posedge clk) disable iff (rst) force_off |=> !en_o);
    // R8
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && en_o && !force_off) |=> en_o);
    // R10
    ext_rdy_set_chk: assert property (@(posedge clk) disable iff (rst) stable_in |=> rdy_o);

endmodule

// File: rtl/osc_field_store.sv
module osc_field_store
    import osc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [TRIM_W-1:0] trim_in,
    input  logic [CAL_W-1:0]  cal_in,
    output logic [TRIM_W-1:0] trim_o,
    output logic [CAL_W-1:0]  cal_o
);
    logic [TRIM_W-1:0] trim_q;
    logic [CAL_W-1:0]  cal_q;
    logic              cal_done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q     <= TRIM_RST;
            cal_q      <= '0;
            cal_done_q <= 1'b0;
        end else begin
            if (wr_hit)
                trim_q <= trim_in;
            if (!cal_done_q) begin
                cal_q      <= cal_in;
                cal_done_q <= 1'b1;
            end
        end
    end

    assign trim_o = trim_q;
    assign cal_o  = cal_q;

    // R2
    cal_frozen_chk: assert property (@(posedge clk) disable iff (rst) cal_done_q |=> $stable(cal_q));

endmodule

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
    import osc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    output logic [31:0]       rdata,
    input  logic              int_stable,
    input  logic              ext_stable,
    input  logic [1:0]        sysclk_src,
    input  logic              pll_from_ext,
    input  logic              por_evt,
    input  logic              swrst_evt,
    input  logic              wake_stop,
    input  logic              wake_standby,
    input  logic              enter_stop,
    input  logic              enter_standby,
    input  logic              ext_fail,
    input  logic [7:0]        cal_in,
    output logic              int_osc_en,
    output logic              ext_osc_en,
    output logic [4:0]        trim_out
);
    localparam int EXT_EN_BIT  = 16;
    localparam int EXT_RDY_BIT = 17;

    clk_src_e  src;
    logic      hit, wr_b0, wr_b2;
    logic      int_lock, ext_lock;
    logic      int_force, ext_force;
    logic      int_rdy, ext_rdy;
    logic [CAL_W-1:0] cal;
    osc_word_t view;
    logic      unused_bits;

    assign src       = clk_src_e'(sysclk_src);
    assign hit       = wr_en && (addr == REG_OFFSET);
    assign wr_b0     = hit && wstrb[0];
    assign wr_b2     = hit && wstrb[2];
    assign int_lock  = drives_sysclk(src, pll_from_ext, 1'b0);
    assign ext_lock  = drives_sysclk(src, pll_from_ext, 1'b1);
    assign int_force = por_evt | swrst_evt | wake_stop | wake_standby | (ext_fail & ext_lock);
    assign ext_force = enter_stop | enter_standby;

    osc_int_ctl u_int (
        .clk       (clk),
        .rst       (rst),
        .wr_hit    (wr_b0),
        .wr_val    (wdata[0]),
        .locked    (int_lock),
        .force_on  (int_force),
        .stable_in (int_stable),
        .en_o      (int_osc_en),
        .rdy_o     (int_rdy)
    );

    osc_ext_ctl u_ext (
        .clk        (clk),
        .rst        (rst),
        .wr_hit     (wr_b2),
        .wr_en_val  (wdata[EXT_EN_BIT]),
        .wr_rdy_val (wdata[EXT_RDY_BIT]),
        .locked     (ext_lock),
        .force_off  (ext_force),
        .stable_in  (ext_stable),
        .en_o       (ext_osc_en),
        .rdy_o      (ext_rdy)
    );

    osc_field_store u_fields (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_b0),
        .trim_in (wdata[TRIM_LSB +: TRIM_W]),
        .cal_in  (cal_in),
        .trim_o  (trim_out),
        .cal_o   (cal)
    );

    always_comb begin
        view         = '0;
        view.int_en  = int_osc_en;
        view.int_rdy = int_rdy;
        view.trim    = trim_out;
        view.cal     = cal;
        view.ext_en  = ext_osc_en;
        view.ext_rdy = ext_rdy;
        rdata        = (rd_en && addr == REG_OFFSET) ? view : 32'h0;
    end

    assign unused_bits = ^{wdata[31:18], wdata[15:8], wdata[2:1], wstrb[3], wstrb[1]};

    // R7
    fail_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_fail && !ext_lock && !int_lock && !por_evt && !swrst_evt && !wake_stop
         && !wake_standby && !wr_b0) |=> $stable(int_osc_en));
    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rdata[31:18] == 14'h0 && rdata[2] == 1'b0));

endmodule

// File: tb/test_osc_ctrl_reg.sv
`timescale 1ns/1ps
module test_osc_ctrl_reg;

    typedef struct {
        logic [31:0] exp;
        logic        pins;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [3:0]  wstrb = 0;
    logic [31:0] rdata;
    logic        int_stable = 1, ext_stable = 0;
    logic [1:0]  sysclk_src = 2'b00;
    logic        pll_from_ext = 0;
    logic [3:0]  wk = 0;
    logic [1:0]  lp = 0;
    logic        ext_fail = 0;
    logic [7:0]  cal_in = 8'hA5;
    logic        int_osc_en, ext_osc_en;
    logic [4:0]  trim_out;

    int checks = 0;
    int errors = 0;
    item_t sb[$];

    always #5 clk = ~clk;

    osc_ctrl_reg i_osc_ctrl_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .rdata(rdata),
        .int_stable(int_stable), .ext_stable(ext_stable),
        .sysclk_src(sysclk_src), .pll_from_ext(pll_from_ext),
        .por_evt(wk[0]), .swrst_evt(wk[1]), .wake_stop(wk[2]), .wake_standby(wk[3]),
        .enter_stop(lp[0]), .enter_standby(lp[1]), .ext_fail(ext_fail),
        .cal_in(cal_in), .int_osc_en(int_osc_en), .ext_osc_en(ext_osc_en),
        .trim_out(trim_out)
    );

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rd_en && sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected %h", it.tag, rdata, it.exp);
                end
                if (it.pins && (int_osc_en !== it.exp[0] || ext_osc_en !== it.exp[16]
                                || trim_out !== it.exp[7:3])) begin
                    errors++;
                    $display("FAIL %s: pins int=%b ext=%b trim=%h expected int=%b ext=%b trim=%h",
                             it.tag, int_osc_en, ext_osc_en, trim_out,
                             it.exp[0], it.exp[16], it.exp[7:3]);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, with optional write and event pulses
    task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d,
                         input logic [3:0] s, input logic [3:0] wkv, input logic [1:0] lpv,
                         input logic fail, input logic es);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; wstrb = s;
        wk = wkv; lp = lpv; ext_fail = fail; ext_stable = es;
        @(negedge clk);
        wr_en = 0; addr = 0; wdata = 0; wstrb = 0;
        wk = 0; lp = 0; ext_fail = 0; ext_stable = 0;
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] s);
        drive(1'b1, 8'h00, d, s, 4'h0, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] exp, input logic pins,
                       input string tag);
        item_t it;
        it.exp = exp; it.pins = pins; it.tag = tag;
        @(negedge clk);
        addr = a; rd_en = 1;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 0; addr = 0;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(8'h00, 32'h0000_0083, 1'b1, "R1 reset value");
        @(negedge clk) rst = 0;
        @(negedge clk) cal_in = 8'h5A;
        chk(8'h00, 32'h0000_A583, 1'b1, "R2 calibration captured");
        wr(32'h0000_FF00, 4'b0010);
        chk(8'h00, 32'h0000_A583, 1'b1, "R2 calibration write ignored");

        // Internal source is locked: bit 0 stays set, trim updated, byte 2 untouched
        wr(32'h0001_00FF, 4'b0001);
        chk(8'h00, 32'h0000_A5FB, 1'b1, "R3 byte strobe and trim");

        sysclk_src = 2'b01;
        wr(32'h0000_0000, 4'b0001);
        chk(8'h00, 32'h0000_A500, 1'b1, "R4 internal clear, R11 ready low");
        wr(32'h0000_0001, 4'b0001);
        chk(8'h00, 32'h0000_A503, 1'b1, "R4 internal set");

        sysclk_src = 2'b10; pll_from_ext = 0;
        wr(32'h0000_0000, 4'b0001);
        chk(8'h00, 32'h0000_A503, 1'b1, "R5 clear ignored via PLL");

        sysclk_src = 2'b00;
        wr(32'h0001_0000, 4'b0100);
        chk(8'h00, 32'h0001_A503, 1'b1, "R8 external set");

        drive(1'b0, 8'h00, 32'h0, 4'h0, 4'h0, 2'b00, 1'b0, 1'b1);
        chk(8'h00, 32'h0003_A503, 1'b1, "R10 ready set by stable");
        wr(32'h0001_0000, 4'b0100);
        chk(8'h00, 32'h0001_A503, 1'b1, "R10 ready cleared by write 0");
        drive(1'b1, 8'h00, 32'h0001_0000, 4'b0100, 4'h0, 2'b00, 1'b0, 1'b1);
        chk(8'h00, 32'h0003_A503, 1'b1, "R10 stable wins over clear");
        wr(32'h0001_0000, 4'b0100);
        wr(32'h0003_0000, 4'b0100);
        chk(8'h00, 32'h0001_A503, 1'b1, "R10 write 1 has no effect");

        sysclk_src = 2'b01;
        wr(32'h0000_0000, 4'b0100);
        chk(8'h00, 32'h0001_A503, 1'b1, "R8 clear ignored, direct");
        sysclk_src = 2'b10; pll_from_ext = 1;
        wr(32'h0000_0000, 4'b0100);
        chk(8'h00, 32'h0001_A503, 1'b1, "R8 clear ignored via PLL");

        wr(32'h0000_0000, 4'b0001);
        chk(8'h00, 32'h0001_A500, 1'b1, "R4 clear with PLL on external");
        drive(1'b0, 8'h00, 32'h0, 4'h0, 4'h0, 2'b00, 1'b1, 1'b0);
        chk(8'h00, 32'h0001_A503, 1'b1, "R7 failure forces internal on");

        sysclk_src = 2'b11;
        wr(32'h0000_0000, 4'b0001);
        drive(1'b0, 8'h00, 32'h0, 4'h0, 4'h0, 2'b00, 1'b1, 1'b0);
        chk(8'h00, 32'h0001_A500, 1'b1, "R7 failure ignored when not feeding");

        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 8'h00, 32'h0, 4'b0001, 4'(1 << k), 2'b00, 1'b0, 1'b0);
            chk(8'h00, 32'h0001_A503, 1'b1, $sformatf("R6 event %0d beats write 0", k));
            wr(32'h0000_0000, 4'b0001);
        end
        wr(32'h0000_0001, 4'b0001);

        int_stable = 0;
        chk(8'h00, 32'h0001_A501, 1'b1, "R11 ready follows stable low");
        int_stable = 1;
        chk(8'h00, 32'h0001_A503, 1'b1, "R11 ready follows stable high");

        drive(1'b1, 8'h00, 32'h0001_0000, 4'b0100, 4'h0, 2'b01, 1'b0, 1'b0);
        chk(8'h00, 32'h0000_A503, 1'b1, "R9 stop entry beats write 1");
        wr(32'h0001_0000, 4'b0100);
        drive(1'b0, 8'h00, 32'h0, 4'h0, 4'h0, 2'b10, 1'b0, 1'b0);
        chk(8'h00, 32'h0000_A503, 1'b1, "R9 standby entry clears");

        chk(8'h04, 32'h0000_0000, 1'b0, "R12 other address reads 0");
        wr(32'hFFFF_FFFF, 4'b1000);
        chk(8'h00, 32'h0000_A503, 1'b1, "R12 byte 3 write ignored");
        drive(1'b1, 8'h04, 32'h0000_0000, 4'b1111, 4'h0, 2'b00, 1'b0, 1'b0);
        chk(8'h00, 32'h0000_A503, 1'b1, "R12 other address write ignored");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule